// File: doc/BRIEF.md
# Buffered 16-bit peripheral timer

This block is a 16-bit up-counter reached through an 8-bit register bus. Four addresses select the low byte, the high byte, a control register and an overflow flag register. The count is advanced by one of two clock sources. The first is an internal tick at one quarter of the system clock. The second is an external clock input, detected on its rising edges. The chosen source passes through a prescaler that divides by 1, 2, 4 or 8. When the count wraps past 0xFFFF, a sticky flag is set. A trigger input clears the count.

In buffered mode, software can read or write all 16 bits as one coherent value. Reading the low byte captures the live high byte into a holding register, and the high-byte address then returns that held value. Writing the high-byte address fills only the holding register. The next low-byte write loads both bytes of the counter at once. With buffered mode off, both byte addresses reach the counter directly.

Top module: `buf_timer16`

## Requirements
- R1: After reset the counter, holding register, control register, prescaler and flag are all zero. `rd_data` reads 0 at every address and `ovf_flag` is 0.
- R2: The control register sits at address 2 and reads back what was written. Its fields are: bit0 run enable, bit1 external source select (1 = external input), bit2 synchronizer enable, bits 5:4 prescale select, bit7 buffered mode. All other bits read 0.
- R3: With buffered mode off, address 0 reads and writes the counter low byte and address 1 reads and writes the counter high byte. Each write takes effect at the next clock edge, and a low-byte write leaves the high byte unchanged.
- R4: With buffered mode on, a read strobe at address 0 copies the live high byte into the holding register at that edge. Address 1 then reads the holding register, so it keeps the value captured before any later rollover.
- R5: With buffered mode on, a write to address 1 loads only the holding register and leaves the live count unchanged. A write to address 0 loads the low byte from the bus and the high byte from the holding register in the same edge.
- R6: Prescale select 0, 1, 2 and 3 advance the counter once per 1, 2, 4 and 8 source ticks. Counting starts from a cleared prescaler.
- R7: A write to address 0 clears the prescaler. A write to address 1 does not clear it.
- R8: With the internal source selected and prescale 1, the counter advances by exactly 10 over any 40 consecutive system clock cycles.
- R9: Take an external input rise driven between clock edges. With the synchronizer disabled, the counter advances at the second following edge. With the synchronizer enabled, it advances at the third following edge.
- R10: A wrap from 0xFFFF to 0x0000 sets `ovf_flag`, which is also bit0 of address 3. The flag stays set until a write to address 3 with bit0 = 0. If a wrap and such a write fall in the same cycle, the flag is set.
- R11: A high `trig_clr` at an edge clears the 16-bit count. It takes priority over bus writes and counting in that cycle.
- R12: With the run bit clear, no source tick changes the counter or the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 low, 1 high, 2 control, 3 flag |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; only its side effect on the holding register depends on it |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `bus_addr`, combinational |
| ext_clk | input | 1 | External count clock |
| trig_clr | input | 1 | Clears the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Read data is combinational, so the bench samples `rd_data` in the same cycle as the strobe. A write appears on the next read, because it lands at the edge that closes its cycle. The holding-register capture happens at the edge that ends the low-byte read, which means the coherence test issues the high-byte read only after that edge and after an external tick has rolled the counter. External ticks come two edges after an input rise in bypass mode and three edges after it with the synchronizer. The bench samples between those edges to separate the two modes. Pulse-count tests wait four cycles after the last pulse before reading. The overflow-versus-clear race is lined up so that both events land on the same edge.

// File: rtl/buf_timer16.sv
module buf_timer16 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       ext_clk,
  input  logic       trig_clr,
  output logic       ovf_flag
);
  logic [15:0] cnt;
  logic [7:0]  hbuf;
  logic        run, ext_sel, sync_en, buf_mode;
  logic [1:0]  ps_sel;
  logic [2:0]  ps;
  logic [1:0]  div;
  logic        e1, e2, e3;

  wire wr_lo   = wr_en && bus_addr == 2'd0;
  wire wr_hi   = wr_en && bus_addr == 2'd1;
  wire wr_ctl  = wr_en && bus_addr == 2'd2;
  wire wr_flg  = wr_en && bus_addr == 2'd3;
  wire rd_lo   = rd_en && bus_addr == 2'd0;

  wire ext_edge = sync_en ? (e2 & ~e3) : (e1 & ~e2);
  wire tick     = run && (ext_sel ? ext_edge : (div == 2'd3));
  wire [2:0] mask = {ps_sel == 2'd3, ps_sel[1], ps_sel != 2'd0};
  wire inc      = tick && ((ps & mask) == mask);
  wire cnt_busy = trig_clr || wr_lo || (wr_hi && !buf_mode);
  wire wrap     = inc && !cnt_busy && cnt == 16'hFFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {e1, e2, e3} <= 3'b000;
      div <= 2'd0;
    end else begin
      {e1, e2, e3} <= {ext_clk, e1, e2};
      div <= div + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; ext_sel <= 1'b0; sync_en <= 1'b0;
      buf_mode <= 1'b0; ps_sel <= 2'd0;
    end else if (wr_ctl) begin
      run      <= wr_data[0];
      ext_sel  <= wr_data[1];
      sync_en  <= wr_data[2];
      ps_sel   <= wr_data[5:4];
      buf_mode <= wr_data[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ps <= 3'd0;
    else if (wr_lo) ps <= 3'd0;
    else if (tick)  ps <= ps + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= 16'd0;
    else if (trig_clr)            cnt <= 16'd0;
    else if (wr_lo)               cnt <= {buf_mode ? hbuf : cnt[15:8], wr_data};
    else if (wr_hi && !buf_mode)  cnt[15:8] <= wr_data;
    else if (inc)                 cnt <= cnt + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   hbuf <= 8'd0;
    else if (wr_hi && buf_mode)   hbuf <= wr_data;
    else if (rd_lo && buf_mode)   hbuf <= cnt[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     ovf_flag <= 1'b0;
    else if (wrap)                  ovf_flag <= 1'b1;
    else if (wr_flg && !wr_data[0]) ovf_flag <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    rd_data = cnt[7:0];
      2'd1:    rd_data = buf_mode ? hbuf : cnt[15:8];
      2'd2:    rd_data = {buf_mode, 1'b0, ps_sel, 1'b0, sync_en, ext_sel, run};
      default: rd_data = {7'd0, ovf_flag};
    endcase
  end
endmodule

module buf_timer16_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wr_data,
  input logic        trig_clr,
  input logic        run,
  input logic        buf_mode,
  input logic [15:0] cnt,
  input logic [7:0]  hbuf,
  input logic        ovf_flag
);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !(wr_en && bus_addr == 2'd3 && !wr_data[0]) |=> ovf_flag);

  assert_trig_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_clr |=> cnt == 16'd0);

  assert_low_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == 2'd0 && !trig_clr |=> cnt[7:0] == $past(wr_data));

  assert_buf_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && bus_addr == 2'd0 && buf_mode && !(wr_en && bus_addr == 2'd1)
    |=> hbuf == $past(cnt[15:8]));

  assert_buf_high_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && bus_addr == 2'd1 && buf_mode && !trig_clr |=> cnt[15:8] == $past(cnt[15:8]));

  assert_run_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !trig_clr && !wr_en |=> $stable(cnt));
endmodule

bind buf_timer16 buf_timer16_chk chk_i (.*);

// File: tb/buf_timer16_tb.sv
module buf_timer16_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ext_clk = 0, trig_clr = 0;
  logic       ovf_flag;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  buf_timer16 dut_i (.*);

  // {prescale select, pulse count, expected count}
  localparam logic [15:0] VEC [5] = '{
    {2'd0, 6'd5,  8'd5},
    {2'd1, 6'd7,  8'd3},
    {2'd2, 6'd9,  8'd2},
    {2'd3, 6'd17, 8'd2},
    {2'd3, 6'd7,  8'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; rd_en = 1; #1 d = rd_data;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1;
      repeat (3) @(negedge clk);
      ext_clk = 0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reset read", v, 0); end
    chk("R1 reset flag", ovf_flag, 0);

    // R2 control readback
    wr(2, 8'hFF); rd(2, v); chk("R2 ctrl readback", v, 8'hB7);
    wr(2, 8'h00);

    // R6/R7 vector walk with external bypassed source
    foreach (VEC[k]) begin
      wr(2, 8'h03 | (8'(VEC[k][15:14]) << 4));
      wr(1, 0); wr(0, 0);
      pulse(int'(VEC[k][13:8]));
      rd(0, v); chk("R6 prescale count low", v, VEC[k][7:0]);
      rd(1, v); chk("R6 prescale count high", v, 0);
    end

    // R7 high write keeps prescaler, low write clears it (divide by 2)
    wr(2, 8'h13); wr(0, 0); pulse(1); wr(1, 0); pulse(1);
    rd(0, v); chk("R7 high write keeps prescaler", v, 1);
    wr(0, 0); pulse(1); wr(0, 0); pulse(1);
    rd(0, v); chk("R7 low write clears prescaler", v, 0);

    // R3 direct access, low write keeps high byte
    wr(2, 8'h00); wr(1, 8'hA5); wr(0, 8'h3C);
    rd(1, v); chk("R3 direct high", v, 8'hA5);
    rd(0, v); chk("R3 direct low", v, 8'h3C);

    // R12 run clear: ticks ignored
    wr(2, 8'h02); pulse(3);
    rd(0, v); chk("R12 stopped low", v, 8'h3C);
    rd(1, v); chk("R12 stopped high", v, 8'hA5);

    // R9 latency, bypass then sync
    wr(2, 8'h03); wr(1, 0); wr(0, 8'h10);
    @(negedge clk); bus_addr = 0; ext_clk = 1;
    @(posedge clk); @(posedge clk); #2 chk("R9 bypass at 2nd edge", rd_data, 8'h11);
    repeat (3) @(negedge clk); ext_clk = 0; repeat (4) @(negedge clk);
    wr(2, 8'h07); wr(0, 8'h20);
    @(negedge clk); bus_addr = 0; ext_clk = 1;
    @(posedge clk); @(posedge clk); #2 chk("R9 sync not yet at 2nd edge", rd_data, 8'h20);
    @(posedge clk); #2 chk("R9 sync at 3rd edge", rd_data, 8'h21);
    repeat (3) @(negedge clk); ext_clk = 0; repeat (4) @(negedge clk);

    // R8 internal source: 10 counts in 40 cycles
    wr(2, 8'h01); wr(0, 0);
    repeat (39) @(posedge clk);
    #2 bus_addr = 0; #1 chk("R8 internal rate", rd_data, 10);
    wr(2, 8'h00);

    // R10 overflow and clear
    wr(2, 8'h03); wr(1, 8'hFF); wr(0, 8'hFE);
    pulse(1); chk("R10 no flag at FFFF", ovf_flag, 0);
    pulse(1); chk("R10 flag on wrap", ovf_flag, 1);
    rd(0, v); chk("R10 wrapped to zero", v, 0);
    rd(3, v); chk("R10 flag register", v, 1);
    wr(3, 8'h01); chk("R10 writing one keeps flag", ovf_flag, 1);
    wr(3, 8'h00); chk("R10 flag cleared", ovf_flag, 0);
    // R10 wrap and clear in the same cycle
    wr(1, 8'hFF); wr(0, 8'hFF);
    @(negedge clk); ext_clk = 1;
    @(posedge clk);
    @(negedge clk); bus_addr = 3; wr_data = 0; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
    #2 chk("R10 wrap beats clear", ovf_flag, 1);
    repeat (3) @(negedge clk); ext_clk = 0; repeat (4) @(negedge clk);
    wr(3, 0);

    // R11 trigger clears count, beats a write
    wr(2, 8'h00); wr(1, 8'h44); wr(0, 8'h55);
    @(negedge clk); trig_clr = 1; @(posedge clk); #1 trig_clr = 0;
    rd(0, v); rd(1, w); chk("R11 trigger clears", {w, v}, 0);
    @(negedge clk); trig_clr = 1; bus_addr = 0; wr_data = 8'h77; wr_en = 1;
    @(posedge clk); #1 trig_clr = 0; wr_en = 0;
    rd(0, v); chk("R11 trigger beats write", v, 0);

    // R5 buffered write commits both bytes
    wr(2, 8'h80); wr(1, 8'h12);
    rd(0, v); chk("R5 high write leaves live count", v, 0);
    rd(2, v); wr(2, 8'h00); rd(1, v); chk("R5 live high untouched", v, 0);
    wr(2, 8'h80); wr(1, 8'h12); wr(0, 8'h34);
    wr(2, 8'h00); rd(1, v); rd(0, w); chk("R5 committed value", {v, w}, 16'h1234);

    // R4 coherent read across rollover
    wr(1, 8'h12); wr(0, 8'hFF); wr(2, 8'h83);
    rd(0, v); chk("R4 low byte before roll", v, 8'hFF);
    pulse(1);
    rd(1, v); chk("R4 buffered high coherent", v, 8'h12);
    rd(0, v); chk("R4 low after roll", v, 8'h00);
    rd(1, v); chk("R4 high recaptured", v, 8'h13);

    finish_run();
  end
endmodule